// File: doc/BRIEF.md
# Piecewise Linear Gamma Evaluator

This block applies a programmable transfer curve to each colour component of a pixel stream, one pixel per clock. Each component of each display channel has a curve made of 16 linear segments. Each segment has three parts: a breakpoint, an offset and an unsigned gradient. For every input code the block picks the highest segment whose breakpoint does not exceed the code. It multiplies the distance from that breakpoint by the gradient and adds the offset. The result is rounded to the nearest code and clamped to the top of the output range.

Segment data is written over a simple word-write port into a shadow copy. A channel's working curves are replaced by its shadow copy only when that channel's frame-start strobe is seen, so a curve never changes partway through a frame. The red, green and blue curves exist on every display channel. The fourth (alpha) curve exists only on one channel; on the other channels alpha is forwarded untouched. Each channel also has a gamma enable input; when it is low, all four components pass straight through.

Top module: `pwl_gamma_eval`

## Requirements
- R1: After reset, out_valid is 0 and every curve on every channel is the identity: point i has breakpoint i*256, offset i*256 in U12.4 and gradient 1.0 in U4.8 (256). Any pixel with gamma enabled therefore comes out equal to its input.
- R2: A pixel sampled with in_valid high at clock edge n appears on the outputs after edge n+1, together with its out_dch; out_valid is high exactly in those cycles.
- R3: A write at byte address 0x2000 + ch*0x400 + comp*0x80 + pt*8 + w*4 targets point pt (0..15) of component comp (0 red, 1 green, 2 blue, 3 alpha) on channel ch. Word w=0 loads the breakpoint from bits [31:20] and the U12.4 offset from bits [15:0]. Word w=1 loads the U4.8 gradient from bits [11:0].
- R4: The segment used is the highest-indexed point whose breakpoint is less than or equal to the input. If the input is below every breakpoint, point 0 is used with a distance of 0.
- R5: The output is floor((G*(in - X) + 16*C + 128) / 256): the full-precision sum is rounded half up.
- R6: Results above 4095 are clamped to 4095.
- R7: The alpha curve is applied only on channel 2. On channels 0 and 1 alpha passes unchanged, and writes to their alpha region (comp 3) change nothing.
- R8: Writes reach a channel's working curve only at a cycle where that channel's frame_start bit is high. A pixel sampled in that same cycle still uses the old curve, and a write in that same cycle waits for the next frame start.
- R9: When gamma_en for the pixel's channel is low, or in_dch is 3, all four components pass unchanged.
- R10: Writes outside the map change no curve: channel index 3 (0x2C00 and up), or comp 4..7 within a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment word write strobe |
| wr_addr | input | 14 | Byte address of the word |
| wr_data | input | 32 | Word data |
| frame_start | input | 3 | Per-channel frame start; commits shadow curves |
| gamma_en | input | 3 | Per-channel curve enable |
| in_valid | input | 1 | Input pixel valid |
| in_dch | input | 2 | Display channel of the input pixel |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| in_a | input | 12 | Alpha input |
| out_valid | output | 1 | Output pixel valid |
| out_dch | output | 2 | Display channel of the output pixel |
| out_r | output | 12 | Red output |
| out_g | output | 12 | Green output |
| out_b | output | 12 | Blue output |
| out_a | output | 12 | Alpha output |

## Verification
A corrupted working or shadow entry shows up only when a pixel falls in that segment, on the channel and component that own it. The bench therefore steers pixels into each programmed segment and into the segments next to any mis-decoded address. A commit that fires too early or too late changes the output of the first pixel sampled after the write or after the strobe, two edges later. A wrong segment choice or rounding error shows as an output a few codes off, right at the breakpoints and at half-code sums.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;
   localparam int XMAX_W     = 12;
   localparam int C_W        = 16;
   localparam int G_W        = 12;
   localparam int G_FRAC     = 8;
   localparam int NUM_COMP   = 4;
   localparam int COMP_ALPHA = 3;
   localparam int WORD_W     = 32;

   typedef struct packed {
      logic [XMAX_W-1:0] x;
      logic [C_W-1:0]    c;
      logic [G_W-1:0]    g;
   } pwl_pt_t;
endpackage

// File: rtl/pwl_gamma_regs.sv
module pwl_gamma_regs
   import pwl_gamma_pkg::*;
#(
   parameter int NUM_DCH   = 3,
   parameter int NUM_PTS   = 16,
   parameter int PIX_W     = 12,
   parameter int ADDR_W    = 14,
   parameter int BASE      = 'h2000,
   parameter int STRIDE    = 'h400,
   parameter int ALPHA_DCH = 2,
   parameter int DCH_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [NUM_DCH-1:0] frame_start,
   input  logic [DCH_W-1:0]  rd_dch,
   output pwl_pt_t           rd_tbl [NUM_COMP][NUM_PTS]
);
   localparam int PT_W   = $clog2(NUM_PTS);
   localparam int STR_W  = $clog2(STRIDE);
   localparam int CMP_W  = STR_W - PT_W - 3;
   localparam int CI_W   = $clog2(NUM_COMP);
   localparam int DI_W   = $clog2(NUM_DCH);
   localparam int CF     = C_W - PIX_W;
   localparam int XSTEP  = (1 << PIX_W) / NUM_PTS;

   pwl_pt_t shd [NUM_DCH][NUM_COMP][NUM_PTS];
   pwl_pt_t act [NUM_DCH][NUM_COMP][NUM_PTS];

   logic [ADDR_W-1:0]       off;
   logic [ADDR_W-STR_W-1:0] w_dch;
   logic [CMP_W-1:0]        w_cmp;
   logic [PT_W-1:0]         w_pt;
   logic                    w_word, w_hit;
   logic [DI_W-1:0]         wd_i, rd_i;
   logic [CI_W-1:0]         wc_i;
   logic                    unused_bits;

   always_comb begin
      off    = wr_addr - ADDR_W'(BASE);
      w_dch  = off[ADDR_W-1:STR_W];
      w_cmp  = off[STR_W-1:PT_W+3];
      w_pt   = off[PT_W+2:3];
      w_word = off[2];
      wd_i   = DI_W'(w_dch);
      wc_i   = CI_W'(w_cmp);
      w_hit  = wr_en && (wr_addr >= ADDR_W'(BASE)) && (int'(w_dch) < NUM_DCH) &&
               ((int'(w_cmp) < COMP_ALPHA) ||
                (int'(w_cmp) == COMP_ALPHA && int'(w_dch) == ALPHA_DCH));
      rd_i   = (int'(rd_dch) < NUM_DCH) ? DI_W'(rd_dch) : '0;
   end

   assign unused_bits = ^{off[1:0], wr_data[WORD_W-1-PIX_W:C_W]};

   function automatic pwl_pt_t ident(int i);
      pwl_pt_t e;
      e.x = XMAX_W'(i * XSTEP);
      e.c = C_W'((i * XSTEP) << CF);
      e.g = G_W'(1 << G_FRAC);
      return e;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NUM_DCH; d++)
            for (int c = 0; c < NUM_COMP; c++)
               for (int p = 0; p < NUM_PTS; p++) begin
                  shd[d][c][p] <= ident(p);
                  act[d][c][p] <= ident(p);
               end
      end else begin
         for (int d = 0; d < NUM_DCH; d++)
            if (frame_start[d])
               for (int c = 0; c < NUM_COMP; c++)
                  for (int p = 0; p < NUM_PTS; p++)
                     act[d][c][p] <= shd[d][c][p];
         if (w_hit) begin
            if (!w_word) begin
               shd[wd_i][wc_i][w_pt].x <= XMAX_W'(wr_data[WORD_W-1 -: PIX_W]);
               shd[wd_i][wc_i][w_pt].c <= wr_data[C_W-1:0];
            end else begin
               shd[wd_i][wc_i][w_pt].g <= wr_data[G_W-1:0];
            end
         end
      end
   end

   always_comb
      for (int c = 0; c < NUM_COMP; c++)
         for (int p = 0; p < NUM_PTS; p++)
            rd_tbl[c][p] = act[rd_i][c][p];

   // R8: a strobe copies the shadow entry into the working curve
   p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start[0] |=> act[0][0][1] == $past(shd[0][0][1]));

   // R8: without a strobe the working curve holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start[0] |=> $stable(act[0][0][1]));
endmodule

// File: rtl/pwl_gamma_seg.sv
module pwl_gamma_seg
   import pwl_gamma_pkg::*;
#(
   parameter int NUM_PTS = 16,
   parameter int PIX_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix,
   input  logic             use_curve,
   input  pwl_pt_t          tbl [NUM_PTS],
   output logic [PIX_W-1:0] dx_q,
   output logic [C_W-1:0]   c_q,
   output logic [G_W-1:0]   g_q,
   output logic             byp_q,
   output logic [PIX_W-1:0] pix_q
);
   localparam int PT_W = $clog2(NUM_PTS);

   logic [PT_W-1:0]   idx;
   logic [XMAX_W-1:0] pix_x;
   pwl_pt_t           sel;
   logic [PIX_W-1:0]  dx;

   always_comb begin
      pix_x = XMAX_W'(pix);
      idx   = '0;
      for (int i = 0; i < NUM_PTS; i++)
         if (tbl[i].x <= pix_x) idx = PT_W'(i);
      sel = tbl[idx];
      dx  = (pix_x >= sel.x) ? PIX_W'(pix_x - sel.x) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dx_q  <= '0;
         c_q   <= '0;
         g_q   <= '0;
         byp_q <= 1'b1;
         pix_q <= '0;
      end else begin
         dx_q  <= dx;
         c_q   <= sel.c;
         g_q   <= sel.g;
         byp_q <= !use_curve;
         pix_q <= pix;
      end
   end
endmodule

// File: rtl/pwl_gamma_mac.sv
module pwl_gamma_mac
   import pwl_gamma_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] dx,
   input  logic [C_W-1:0]   c,
   input  logic [G_W-1:0]   g,
   input  logic             byp,
   input  logic [PIX_W-1:0] pix,
   output logic [PIX_W-1:0] y
);
   localparam int CF     = C_W - PIX_W;
   localparam int PROD_W = G_W + PIX_W;
   localparam int SUM_W  = PROD_W + 1;
   localparam int YMAX   = (1 << PIX_W) - 1;

   logic [PROD_W-1:0] prod;
   logic [SUM_W-1:0]  sum, rnd;
   logic [PIX_W-1:0]  y_n;

   always_comb begin
      prod = PROD_W'(g) * PROD_W'(dx);
      sum  = SUM_W'(prod) + (SUM_W'(c) << (G_FRAC - CF));
      rnd  = (sum + SUM_W'(1 << (G_FRAC - 1))) >> G_FRAC;
      if (byp)                     y_n = pix;
      else if (rnd > SUM_W'(YMAX)) y_n = PIX_W'(YMAX);
      else                         y_n = PIX_W'(rnd);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) y <= '0;
      else        y <= y_n;

   // R6: a full-scale offset always clamps to the top code
   p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp && c == '1) |=> y == PIX_W'(YMAX));
endmodule

// File: rtl/pwl_gamma_eval.sv
module pwl_gamma_eval
   import pwl_gamma_pkg::*;
#(
   parameter int PIX_W     = 12,
   parameter int NUM_PTS   = 16,
   parameter int NUM_DCH   = 3,
   parameter int ALPHA_DCH = 2,
   parameter int ADDR_W    = 14,
   parameter int BASE      = 'h2000,
   parameter int STRIDE    = 'h400,
   localparam int DCH_W    = $clog2(NUM_DCH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [NUM_DCH-1:0] frame_start,
   input  logic [NUM_DCH-1:0] gamma_en,
   input  logic               in_valid,
   input  logic [DCH_W-1:0]   in_dch,
   input  logic [PIX_W-1:0]   in_r,
   input  logic [PIX_W-1:0]   in_g,
   input  logic [PIX_W-1:0]   in_b,
   input  logic [PIX_W-1:0]   in_a,
   output logic               out_valid,
   output logic [DCH_W-1:0]   out_dch,
   output logic [PIX_W-1:0]   out_r,
   output logic [PIX_W-1:0]   out_g,
   output logic [PIX_W-1:0]   out_b,
   output logic [PIX_W-1:0]   out_a
);
   if (PIX_W < G_FRAC || PIX_W > XMAX_W) begin : g_bad_pix_w
      $error("PIX_W must lie between 8 and 12");
   end
   if ((1 << $clog2(NUM_PTS)) != NUM_PTS || NUM_PTS > (1 << PIX_W)) begin : g_bad_pts
      $error("NUM_PTS must be a power of two no larger than the code range");
   end
   if ((1 << $clog2(STRIDE)) != STRIDE || STRIDE < NUM_COMP * NUM_PTS * 8) begin : g_bad_stride
      $error("STRIDE must be a power of two holding all four curves");
   end
   if (NUM_DCH < 2 || ALPHA_DCH >= NUM_DCH) begin : g_bad_dch
      $error("channel count or alpha channel out of range");
   end

   pwl_pt_t          tbl [NUM_COMP][NUM_PTS];
   logic [PIX_W-1:0] pix_in [NUM_COMP];
   logic [PIX_W-1:0] pix_out [NUM_COMP];
   logic [NUM_COMP-1:0] use_c;
   logic             en_in;
   logic             v1, v2;
   logic [DCH_W-1:0] d1, d2;

   always_comb begin
      en_in = 1'b0;
      for (int d = 0; d < NUM_DCH; d++)
         if (int'(in_dch) == d) en_in = gamma_en[d];
      for (int k = 0; k < NUM_COMP; k++)
         use_c[k] = en_in && (k != COMP_ALPHA || int'(in_dch) == ALPHA_DCH);
   end

   assign pix_in[0] = in_r;
   assign pix_in[1] = in_g;
   assign pix_in[2] = in_b;
   assign pix_in[3] = in_a;

   pwl_gamma_regs #(
      .NUM_DCH(NUM_DCH), .NUM_PTS(NUM_PTS), .PIX_W(PIX_W), .ADDR_W(ADDR_W),
      .BASE(BASE), .STRIDE(STRIDE), .ALPHA_DCH(ALPHA_DCH), .DCH_W(DCH_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .rd_dch(in_dch),
      .rd_tbl(tbl)
   );

   for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
      logic [PIX_W-1:0] dx_q, pix_q;
      logic [C_W-1:0]   c_q;
      logic [G_W-1:0]   g_q;
      logic             byp_q;

      pwl_gamma_seg #(.NUM_PTS(NUM_PTS), .PIX_W(PIX_W)) u_seg (
         .clk(clk), .rst_n(rst_n), .pix(pix_in[k]), .use_curve(use_c[k]),
         .tbl(tbl[k]), .dx_q(dx_q), .c_q(c_q), .g_q(g_q), .byp_q(byp_q),
         .pix_q(pix_q)
      );

      pwl_gamma_mac #(.PIX_W(PIX_W)) u_mac (
         .clk(clk), .rst_n(rst_n), .dx(dx_q), .c(c_q), .g(g_q), .byp(byp_q),
         .pix(pix_q), .y(pix_out[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; d1 <= '0; d2 <= '0;
      end else begin
         v1 <= in_valid; v2 <= v1; d1 <= in_dch; d2 <= d1;
      end
   end

   assign out_valid = v2;
   assign out_dch   = d2;
   assign out_r     = pix_out[0];
   assign out_g     = pix_out[1];
   assign out_b     = pix_out[2];
   assign out_a     = pix_out[3];

   // R2: valid leaves two edges after it entered
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   // R9: a disabled channel returns its input codes
   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(en_in, 2)) |->
      {out_r, out_g, out_b, out_a} == $past({in_r, in_g, in_b, in_a}, 2));

   // R7: alpha is forwarded on every channel without an alpha curve
   p_alpha_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'($past(in_dch, 2)) != ALPHA_DCH) |-> out_a == $past(in_a, 2));
endmodule

// File: tb/pwl_gamma_eval_test.sv
`timescale 1ns/1ps
module pwl_gamma_eval_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [13:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  frame_start = '0;
   logic [2:0]  gamma_en = '0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_dch = '0;
   logic [11:0] in_r = '0, in_g = '0, in_b = '0, in_a = '0;
   logic        out_valid;
   logic [1:0]  out_dch;
   logic [11:0] out_r, out_g, out_b, out_a;

   always #10 clk = ~clk;

   pwl_gamma_eval uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_start(frame_start), .gamma_en(gamma_en),
      .in_valid(in_valid), .in_dch(in_dch), .in_r(in_r), .in_g(in_g),
      .in_b(in_b), .in_a(in_a), .out_valid(out_valid), .out_dch(out_dch),
      .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_a(out_a)
   );

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 0;

   int sx [3][4][16], sc [3][4][16], sg [3][4][16];
   int ax [3][4][16], ac [3][4][16], ag [3][4][16];
   bit m1_v = 0, m2_v = 0;
   int m1_d = 0, m2_d = 0;
   int m1_p [4], m2_p [4];

   task automatic chk(bit ok, string what, int a, int e);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, a, e);
      end
   endtask

   function automatic int ev(int d, int k, int p);
      int idx = 0, dx, v;
      if (d > 2 || !gamma_en[d] || (k == 3 && d != 2)) return p;
      for (int i = 0; i < 16; i++) if (ax[d][k][i] <= p) idx = i;
      dx = (p >= ax[d][k][idx]) ? p - ax[d][k][idx] : 0;
      v = (ag[d][k][idx] * dx + ac[d][k][idx] * 16 + 128) / 256;
      return (v > 4095) ? 4095 : v;
   endfunction

   task automatic model_write(int addr, int data);
      int off, d, w, k, pt;
      if (addr < 'h2000) return;
      off = addr - 'h2000;
      d = off / 'h400; w = off % 'h400;
      k = w / 'h80; pt = (w % 'h80) / 8;
      if (d > 2 || k > 3 || (k == 3 && d != 2)) return;
      if (((w / 4) % 2) == 0) begin
         sx[d][k][pt] = (data >> 20) & 'hFFF;
         sc[d][k][pt] = data & 'hFFFF;
      end else begin
         sg[d][k][pt] = data & 'hFFF;
      end
   endtask

   function automatic int pix_of(int k);
      case (k)
         0: return int'(in_r);
         1: return int'(in_g);
         2: return int'(in_b);
         default: return int'(in_a);
      endcase
   endfunction

   task automatic cycle();
      m2_v = m1_v; m2_d = m1_d; m2_p = m1_p;
      m1_v = in_valid; m1_d = int'(in_dch);
      for (int k = 0; k < 4; k++) m1_p[k] = ev(int'(in_dch), k, pix_of(k));
      for (int d = 0; d < 3; d++)
         if (frame_start[d]) begin
            ax[d] = sx[d]; ac[d] = sc[d]; ag[d] = sg[d];
         end
      if (wr_en) model_write(int'(wr_addr), int'(wr_data));
      @(negedge clk);
      chk(out_valid === m2_v, "out_valid", int'(out_valid), int'(m2_v));
      if (m2_v) begin
         chk(int'(out_dch) == m2_d, "out_dch", int'(out_dch), m2_d);
         chk(int'(out_r) == m2_p[0], "out_r", int'(out_r), m2_p[0]);
         chk(int'(out_g) == m2_p[1], "out_g", int'(out_g), m2_p[1]);
         chk(int'(out_b) == m2_p[2], "out_b", int'(out_b), m2_p[2]);
         chk(int'(out_a) == m2_p[3], "out_a", int'(out_a), m2_p[3]);
      end
      wr_en = 0; frame_start = '0; in_valid = 0;
   endtask

   task automatic wr(int addr, int data);
      wr_en = 1; wr_addr = 14'(addr); wr_data = 32'(data);
      cycle();
   endtask

   task automatic wpt(int d, int k, int pt, int x, int c, int g);
      int a = 'h2000 + d * 'h400 + k * 'h80 + pt * 8;
      wr(a, (x << 20) | (c & 'hFFFF));
      wr(a + 4, g);
   endtask

   task automatic px(int d, int r, int g, int b, int a);
      in_valid = 1; in_dch = 2'(d);
      in_r = 12'(r); in_g = 12'(g); in_b = 12'(b); in_a = 12'(a);
      cycle();
   endtask

   task automatic fs(int mask);
      frame_start = 3'(mask);
      cycle();
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int d = 0; d < 3; d++)
         for (int k = 0; k < 4; k++)
            for (int i = 0; i < 16; i++) begin
               sx[d][k][i] = i * 256; sc[d][k][i] = i * 256 * 16; sg[d][k][i] = 256;
            end
      ax = sx; ac = sc; ag = sg;

      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(out_valid === 1'b0, "out_valid in reset", int'(out_valid), 0);
      rst_n = 1;
      gamma_en = 3'b111;

      // R1: identity curves after reset
      foreach (m1_p[i]) ;
      px(0, 0, 1, 255, 256); px(1, 2047, 4095, 3000, 17); px(2, 4095, 0, 256, 3841);
      cycle(); cycle();

      // R2: gaps and back-to-back pixels keep latency and channel tags
      cur_req = "R2";
      px(1, 5, 6, 7, 8); cycle(); px(2, 9, 10, 11, 12); px(0, 13, 14, 15, 16);
      cycle(); cycle(); cycle();

      // R8: writes stay in the shadow until frame start
      cur_req = "R8";
      for (int i = 0; i < 16; i++) wpt(0, 0, i, i * 256, i * 200 * 16, 64 + i * 20);
      px(0, 1000, 1000, 1000, 1000); px(1, 300, 300, 300, 300);
      in_valid = 1; in_dch = 0; in_r = 12'd2100; frame_start = 3'b001;
      cycle();
      px(0, 2100, 5, 5, 5);
      cycle(); cycle();

      // R4: segment choice incl. input below every breakpoint
      cur_req = "R4";
      for (int i = 0; i < 16; i++) wpt(0, 1, i, 100 + i * 250, i * 3000, 300);
      fs(1);
      px(0, 0, 99, 0, 0); px(0, 255, 100, 0, 0); px(0, 256, 349, 0, 0);
      px(0, 257, 350, 0, 0); px(0, 4095, 3850, 0, 0); px(0, 2048, 4095, 0, 0);
      cycle(); cycle();

      // R3 and R5: fields, word order and half-up rounding
      cur_req = "R3";
      wpt(1, 2, 0, 0, 8, 128);
      fs(2);
      cur_req = "R5";
      px(1, 0, 0, 0, 0); px(1, 0, 0, 1, 0); px(1, 0, 0, 2, 0); px(1, 0, 0, 3, 0);
      px(1, 0, 0, 255, 0); px(0, 1001, 1003, 7, 0);
      cycle(); cycle();

      // R6: clamp to the top code
      cur_req = "R6";
      wpt(1, 1, 15, 3840, 'hFFFF, 'hFFF);
      wpt(1, 1, 8, 2048, 4000 * 16, 'h800);
      fs(2);
      px(1, 0, 3840, 0, 0); px(1, 0, 4095, 0, 0); px(1, 0, 2100, 0, 0);
      px(1, 0, 2049, 0, 0); px(1, 0, 2047, 0, 0);
      cycle(); cycle();

      // R7: alpha curve only on channel 2
      cur_req = "R7";
      for (int i = 0; i < 16; i++) wpt(2, 3, i, i * 256, i * 128 * 16, 128);
      wpt(0, 3, 0, 0, 'hFFFF, 'hFFF);
      wpt(1, 3, 5, 0, 'hFFFF, 'hFFF);
      fs(7);
      px(2, 10, 10, 10, 0); px(2, 10, 10, 10, 1001); px(2, 10, 10, 10, 4095);
      px(0, 10, 10, 10, 1001); px(1, 10, 10, 10, 1001); px(0, 100, 100, 3, 0);
      px(1, 1300, 5, 5, 1300);
      cycle(); cycle();

      // R9: gamma disabled or channel index 3
      cur_req = "R9";
      gamma_en = 3'b010;
      px(0, 2100, 99, 1, 2); px(2, 7, 8, 9, 1001); px(1, 0, 4095, 1, 4);
      px(3, 4095, 2100, 3, 4);
      cycle(); cycle();
      gamma_en = 3'b111;

      // R10: writes outside the map change no curve
      cur_req = "R10";
      wr('h1FF8, 'hFFFF); wr('h1FFC, 'hFFF);
      wr('h2C00, 'hFFFF); wr('h2C04, 'hFFF);
      wr('h2200, 'hFFFF); wr('h2204, 'hFFF);
      wr('h2680, 'hFFFF); wr('h2684, 'hFFF);
      wr('h2380, 'hFFFF); wr('h2384, 'hFFF);
      fs(7);
      px(0, 5, 5, 5, 5); px(1, 5, 5, 5, 5); px(2, 5, 5, 5, 5); px(3, 5, 5, 5, 5);
      cycle(); cycle();

      // R2 and R8: mixed stream with random strobes and writes
      cur_req = "R2";
      for (int n = 0; n < 4000; n++) begin
         in_valid = 1'($urandom_range(0, 3) != 0);
         in_dch = 2'($urandom_range(0, 3));
         in_r = 12'($urandom); in_g = 12'($urandom);
         in_b = 12'($urandom); in_a = 12'($urandom);
         frame_start = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'b000;
         if ($urandom_range(0, 3) == 0) begin
            wr_en = 1;
            wr_addr = 14'('h2000 + ($urandom_range(0, 'hBFF) & 'hFFC));
            wr_data = 32'($urandom);
         end
         if ($urandom_range(0, 99) == 0) gamma_en = 3'($urandom);
         cycle();
      end
      cycle(); cycle();

      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, 0, 1);
         report();
         $finish;
      end
   end
endmodule